// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a register-mapped timer with a parameterized number of independent channels. Each channel holds a control word, a reload interval and a live count. The count decrements on prescaled ticks of a selected tick source. A channel can run periodically, reloading itself on every expiry, or run once and stop. Clock-source selection is modelled as a choice between two tick-enable inputs that are synchronous to the block clock: a fast tick and a slow tick.

Software accesses the block through a simple synchronous bus with an address, write data and a write strobe. Read data is a combinational function of the address. One shared register holds the interrupt enables and another holds the pending flags, with one bit per channel in each. Pending flags are cleared by writing ones. A single level interrupt output combines all channels.

Top module: `dcount_timer`

## Requirements
- R1: After synchronous reset, every mapped register reads as zero and `irq_o` is low.
- R2: The address map is as follows. Interrupt enable is at 0x00 and pending status is at 0x04, with bit n belonging to channel n. Channel n has its control word at 0x10*n+0x10, its interval at 0x10*n+0x14 and its count at 0x10*n+0x18. Every other address, including the slots of channels that do not exist, reads as zero and ignores writes.
- R3: Control word fields are: bit 0 run enable, bit 1 reload request, bits 3:2 tick source, bits 6:4 prescaler code and bit 7 single-shot select. Bits 31:8 read as zero, and the written fields read back unchanged.
- R4: Source code 0 selects `tick_slow_i` and code 1 selects `tick_fast_i`. Codes 2 and 3 select no tick. Ticks on the unselected input have no effect, and a channel whose enable bit is clear never changes its count.
- R5: With prescaler code k, the count decrements once for every 2^k selected ticks. The ticks are counted from the moment the channel was enabled.
- R6: When a prescaled tick arrives while the count is 0, the channel expires and its pending bit is set in the same clock edge. A run that starts from value C therefore expires on selected tick (C+1)*2^k.
- R7: In periodic mode (bit 7 clear), expiry loads the count from the interval register and counting continues.
- R8: In single-shot mode (bit 7 set), expiry clears the enable bit in hardware, and the count stays at 0 on later ticks.
- R9: The reload bit clears itself. Writing it as 1 copies the interval into the count at the following clock edge. The bit reads 1 until that edge and reads 0 afterwards.
- R10: A write to a count register loads the count directly. A channel enabled afterwards without a reload request counts down from that value.
- R11: Writing 1 to a status bit clears that pending flag, and writing 0 leaves it unchanged. If an expiry and a clear land on the same edge, the expiry wins.
- R12: `irq_o` is high exactly when some channel has both its pending bit and its enable bit set. It changes in the same cycle as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast_i | input | 1 | Fast tick-enable (source code 1) |
| tick_slow_i | input | 1 | Slow tick-enable (source code 0) |
| bus_addr | input | AW (8) | Register byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined level interrupt |

## Verification
A register write takes effect at the edge that samples the strobe. A tick takes effect at the edge where the tick input is high. The pending flag and `irq_o` update at that same edge, while a reload request lands one edge later. The bench drives every input at a falling edge and reads back one time unit after the next falling edge, so each value is sampled in the cycle in which it becomes due. After any reload request it leaves one idle cycle before ticking. The sweep covers each channel, prescaler codes 0 to 3, both sources and both modes. The expected count, flag, enable bit and interrupt are computed from the tick index alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PSC_W  = 3;
    localparam int PCNT_W = (1 << PSC_W) - 1;
    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_FAST = 2'd1,
        SRC_OFFA = 2'd2,
        SRC_OFFB = 2'd3
    } src_e;

    // Packed so that bit 7 is single-shot and bit 0 is run enable
    typedef struct packed {
        logic             oneshot;
        logic [PSC_W-1:0] psc;
        src_e             src;
        logic             reload;
        logic             en;
    } ctrl_t;

    typedef enum logic [2:0] {
        K_NONE, K_IE, K_ST, K_CTRL, K_IVAL, K_CNT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [11:0] ch;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [15:0] a, input int nch);
        reg_sel_t    r;
        logic [11:0] slot;
        r.kind = K_NONE;
        r.ch   = '0;
        slot   = a[15:4] - 12'd1;
        if (a == 16'h0000) begin
            r.kind = K_IE;
        end else if (a == 16'h0004) begin
            r.kind = K_ST;
        end else if (a >= 16'h0010 && a[1:0] == 2'b00 && int'(slot) < nch) begin
            r.ch = slot;
            case (a[3:2])
                2'd0:    r.kind = K_CTRL;
                2'd1:    r.kind = K_IVAL;
                2'd2:    r.kind = K_CNT;
                default: r.kind = K_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic [PCNT_W-1:0] psc_mask(input logic [PSC_W-1:0] code);
        logic [PCNT_W-1:0] m;
        for (int i = 0; i < PCNT_W; i++) begin
            m[i] = (i < int'(code));
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             src_tick_i,
    input  logic [PSC_W-1:0] code_i,
    output logic             ptick_o
);

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] mask;

    assign mask    = psc_mask(code_i);
    assign ptick_o = run_i && src_tick_i && ((pcnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            pcnt_q <= '0;
        end else if (src_tick_i) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_fast_i,
    input  logic              tick_slow_i,
    input  logic              ctrl_wr_i,
    input  logic              ival_wr_i,
    input  logic              cnt_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic [CW-1:0]     wdata_i,
    output ctrl_t             ctrl_o,
    output logic [CW-1:0]     ival_o,
    output logic [CW-1:0]     cnt_o,
    output logic              expire_o
);

    ctrl_t         ctrl_q;
    logic [CW-1:0] ival_q;
    logic [CW-1:0] cnt_q;
    logic          src_tick;
    logic          ptick;
    logic          tick_use;

    always_comb begin
        case (ctrl_q.src)
            SRC_SLOW: src_tick = tick_slow_i;
            SRC_FAST: src_tick = tick_fast_i;
            default:  src_tick = 1'b0;
        endcase
    end

    tmr_prescaler i_psc (
        .clk        (clk),
        .rst        (rst),
        .run_i      (ctrl_q.en),
        .src_tick_i (src_tick),
        .code_i     (ctrl_q.psc),
        .ptick_o    (ptick)
    );

    // A direct count write or a pending reload takes priority over a tick
    assign tick_use = ptick && !cnt_wr_i && !ctrl_q.reload;
    assign expire_o = tick_use && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr_i) begin
            ctrl_q <= ctrl_t'(ctrl_wdata_i);
        end else begin
            if (ctrl_q.reload) begin
                ctrl_q.reload <= 1'b0;
            end
            if (expire_o && ctrl_q.oneshot) begin
                ctrl_q.en <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ival_q <= '0;
        end else if (ival_wr_i) begin
            ival_q <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_wr_i) begin
            cnt_q <= wdata_i;
        end else if (ctrl_q.reload) begin
            cnt_q <= ival_q;
        end else if (tick_use) begin
            if (cnt_q == '0) begin
                cnt_q <= ctrl_q.oneshot ? '0 : ival_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign ival_o = ival_q;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ie_wr_i,
    input  logic           st_wr_i,
    input  logic [NCH-1:0] wdata_i,
    input  logic [NCH-1:0] expire_i,
    output logic [NCH-1:0] ie_o,
    output logic [NCH-1:0] st_o,
    output logic           irq_o
);

    logic [NCH-1:0] ie_q;
    logic [NCH-1:0] st_q;
    logic [NCH-1:0] clr;

    assign clr = st_wr_i ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= '0;
            st_q <= '0;
        end else begin
            if (ie_wr_i) begin
                ie_q <= wdata_i;
            end
            st_q <= (st_q & ~clr) | expire_i;
        end
    end

    assign ie_o  = ie_q;
    assign st_o  = st_q;
    assign irq_o = |(st_q & ie_q);

endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
    import tmr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = 32,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_fast_i,
    input  logic          tick_slow_i,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o
);

    reg_sel_t                 sel;
    logic                     ie_wr;
    logic                     st_wr;
    logic [NCH-1:0]           ch_ctrlwr;
    logic [NCH-1:0]           ch_ivalwr;
    logic [NCH-1:0]           ch_cwr;
    ctrl_t                    ch_ctrl [NCH];
    logic [NCH-1:0][CW-1:0]   ch_ival;
    logic [NCH-1:0][CW-1:0]   ch_cnt;
    logic [NCH-1:0]           ch_exp;
    logic [NCH-1:0]           ch_en;
    logic [NCH-1:0]           ch_os;
    logic [NCH-1:0]           ch_rpend;
    logic [NCH-1:0]           ie_q;
    logic [NCH-1:0]           st_q;

    assign sel   = decode_addr(16'(bus_addr), NCH);
    assign ie_wr = bus_we && (sel.kind == K_IE);
    assign st_wr = bus_we && (sel.kind == K_ST);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ch_ctrlwr[i] = bus_we && (sel.kind == K_CTRL) && (sel.ch == 12'(i));
        assign ch_ivalwr[i] = bus_we && (sel.kind == K_IVAL) && (sel.ch == 12'(i));
        assign ch_cwr[i]    = bus_we && (sel.kind == K_CNT)  && (sel.ch == 12'(i));

        tmr_channel #(.CW(CW)) i_chan (
            .clk          (clk),
            .rst          (rst),
            .tick_fast_i  (tick_fast_i),
            .tick_slow_i  (tick_slow_i),
            .ctrl_wr_i    (ch_ctrlwr[i]),
            .ival_wr_i    (ch_ivalwr[i]),
            .cnt_wr_i     (ch_cwr[i]),
            .ctrl_wdata_i (bus_wdata[CTRL_W-1:0]),
            .wdata_i      (bus_wdata[CW-1:0]),
            .ctrl_o       (ch_ctrl[i]),
            .ival_o       (ch_ival[i]),
            .cnt_o        (ch_cnt[i]),
            .expire_o     (ch_exp[i])
        );

        assign ch_en[i]    = ch_ctrl[i].en;
        assign ch_os[i]    = ch_ctrl[i].oneshot;
        assign ch_rpend[i] = ch_ctrl[i].reload;
    end

    tmr_irq #(.NCH(NCH)) i_irq (
        .clk      (clk),
        .rst      (rst),
        .ie_wr_i  (ie_wr),
        .st_wr_i  (st_wr),
        .wdata_i  (bus_wdata[NCH-1:0]),
        .expire_i (ch_exp),
        .ie_o     (ie_q),
        .st_o     (st_q),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            K_IE: bus_rdata = DW'(ie_q);
            K_ST: bus_rdata = DW'(st_q);
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (sel.ch == 12'(i)) begin
                        if (sel.kind == K_CTRL) bus_rdata = DW'(ch_ctrl[i]);
                        if (sel.kind == K_IVAL) bus_rdata = DW'(ch_ival[i]);
                        if (sel.kind == K_CNT)  bus_rdata = DW'(ch_cnt[i]);
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int NCH = 2,
    parameter int CW  = 32,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_we,
    input logic [AW-1:0]          bus_addr,
    input logic [DW-1:0]          bus_wdata,
    input logic                   irq_o,
    input logic [NCH-1:0]         ie_q,
    input logic [NCH-1:0]         st_q,
    input logic [NCH-1:0]         ch_en,
    input logic [NCH-1:0]         ch_os,
    input logic [NCH-1:0]         ch_rpend,
    input logic [NCH-1:0]         ch_exp,
    input logic [NCH-1:0]         ch_cwr,
    input logic [NCH-1:0]         ch_ctrlwr,
    input logic [NCH-1:0][CW-1:0] ch_cnt,
    input logic [NCH-1:0][CW-1:0] ch_ival
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_o && st_q == '0 && ie_q == '0));

    // The interrupt only drops after software touches enable or status
    assert_irq_fall_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> ($past(bus_we) && ($past(bus_addr) == AW'(0) || $past(bus_addr) == AW'(4))));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_expire_flags_R6: assert property (@(posedge clk) disable iff (rst)
            ch_exp[i] |=> st_q[i]);

        assert_oneshot_stops_R8: assert property (@(posedge clk) disable iff (rst)
            (ch_exp[i] && ch_os[i] && !ch_ctrlwr[i]) |=> !ch_en[i]);

        assert_reload_copies_R9: assert property (@(posedge clk) disable iff (rst)
            (ch_rpend[i] && !ch_cwr[i] && !ch_ctrlwr[i]) |=>
                (!ch_rpend[i] && ch_cnt[i] == $past(ch_ival[i])));

        assert_w1c_clears_R11: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == AW'(4) && bus_wdata[i] && !ch_exp[i]) |=> !st_q[i]);

        assert_step_one_R5: assert property (@(posedge clk) disable iff (rst)
            (ch_en[i] && !ch_cwr[i] && !ch_rpend[i] && ch_cnt[i] != '0) |=>
                (ch_cnt[i] == $past(ch_cnt[i]) || ch_cnt[i] == $past(ch_cnt[i]) - 1'b1));

        assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
            (!ch_en[i] && !ch_cwr[i] && !ch_rpend[i]) |=> $stable(ch_cnt[i]));
    end

endmodule

bind dcount_timer tmr_checker #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) i_tmr_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .ie_q      (ie_q),
    .st_q      (st_q),
    .ch_en     (ch_en),
    .ch_os     (ch_os),
    .ch_rpend  (ch_rpend),
    .ch_exp    (ch_exp),
    .ch_cwr    (ch_cwr),
    .ch_ctrlwr (ch_ctrlwr),
    .ch_cnt    (ch_cnt),
    .ch_ival   (ch_ival)
);

// File: tb/test_dcount_timer.sv
module test_dcount_timer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcount_timer i_dcount_timer (
        .clk         (clk),
        .rst         (rst),
        .tick_fast_i (tick_fast),
        .tick_slow_i (tick_slow),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .bus_rdata   (bus_rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse(input bit fast);
        @(negedge clk);
        if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
        @(negedge clk);
        tick_fast = 1'b0; tick_slow = 1'b0;
    endtask

    task automatic run_case(input int ch, input int k, input int src, input bit os, input int c0);
        logic [31:0] d;
        logic [7:0]  base;
        bit          ie_on;
        int          per, total, exp_cnt;
        base  = 8'(8'h10 + 16 * ch);
        ie_on = bit'(ch) ^ os;
        per   = (c0 + 1) << k;
        total = os ? per + (1 << k) + 1 : 2 * per;
        wr(8'h00, ie_on ? (32'd1 << ch) : 32'd0);
        wr(base + 8'h4, 32'(c0));
        wr(base, {24'd0, os, 3'(k), 2'(src), 1'b1, 1'b1});
        @(negedge clk);
        for (int t = 1; t <= total; t++) begin
            pulse(src == 0);           // unselected source must not count (R4)
            pulse(src == 1);
            if (os) exp_cnt = (t < per) ? c0 - (t >> k) : 0;
            else    exp_cnt = c0 - ((t % per) >> k);
            rd(base + 8'h8, d);
            chk(os ? "R8 oneshot count" : "R7 periodic count R5", d, 32'(exp_cnt));
            rd(8'h04, d);
            chk("R6 pending flag", d[ch], 32'(t >= per));
            chk("R12 irq level", 32'(irq), 32'((t >= per) && ie_on));
            if (os) begin
                rd(base, d);
                chk("R8 enable cleared", d[0], 32'(t < per));
            end
        end
        wr(base, 32'd0);
        wr(8'h04, 32'h3);
        rd(8'h04, d);
        chk("R11 status cleared", d, 32'd0);
        chk("R12 irq low", 32'(irq), 32'd0);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        foreach (d[i]) if (i < 1) begin end
        for (int a = 0; a < 64; a += 4) begin
            rd(8'(a), d);
            chk("R1 reset reads zero", d, 32'd0);
        end
        chk("R1 irq low after reset", 32'(irq), 32'd0);

        // R3 field readback, source codes 2/3 select no tick (R4)
        wr(8'h10, 32'hFFFF_FFFD);
        rd(8'h10, d);
        chk("R3 ctrl readback", d, 32'h0000_00FD);
        for (int t = 0; t < 4; t++) begin pulse(1'b1); pulse(1'b0); end
        rd(8'h18, d);
        chk("R4 source code 3 no count", d, 32'd0);
        wr(8'h10, 32'h0000_0009);
        for (int t = 0; t < 4; t++) begin pulse(1'b1); pulse(1'b0); end
        rd(8'h18, d);
        chk("R4 source code 2 no count", d, 32'd0);
        wr(8'h10, 32'd0);

        // R9 reload self-clears one edge later
        wr(8'h24, 32'd5);
        wr(8'h20, 32'h2);
        rd(8'h20, d);
        chk("R9 reload pending reads 1", d, 32'h2);
        rd(8'h28, d);
        chk("R9 count not yet copied", d, 32'd0);
        @(negedge clk);
        rd(8'h20, d);
        chk("R9 reload reads 0", d, 32'h0);
        rd(8'h28, d);
        chk("R9 count copied", d, 32'd5);
        for (int t = 0; t < 3; t++) pulse(1'b1);
        rd(8'h28, d);
        chk("R4 disabled channel holds", d, 32'd5);

        // R2 unmapped addresses
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h38, 32'hFFFF_FFFF);
        foreach (d[i]) if (i < 1) begin end
        rd(8'h08, d); chk("R2 unmapped 0x08", d, 32'd0);
        rd(8'h0C, d); chk("R2 unmapped 0x0C", d, 32'd0);
        rd(8'h1C, d); chk("R2 unmapped 0x1C", d, 32'd0);
        rd(8'h38, d); chk("R2 absent channel", d, 32'd0);
        rd(8'h00, d); chk("R2 enable untouched", d, 32'd0);
        rd(8'h04, d); chk("R2 status untouched", d, 32'd0);
        rd(8'h10, d); chk("R2 ctrl0 untouched", d, 32'd0);
        rd(8'h28, d); chk("R2 count1 untouched", d, 32'd5);

        // R10 direct count load, then enable without reload
        wr(8'h18, 32'd7);
        rd(8'h18, d);
        chk("R10 count written", d, 32'd7);
        wr(8'h10, 32'h85);
        for (int t = 1; t <= 8; t++) begin
            pulse(1'b1);
            rd(8'h04, d);
            chk("R10 expiry on tick 8", d[0], 32'(t == 8));
        end
        wr(8'h04, 32'h1);

        // R11 / R12 with both channels pending
        wr(8'h18, 32'd0); wr(8'h28, 32'd0);
        wr(8'h10, 32'h85); wr(8'h20, 32'h85);
        pulse(1'b1);
        rd(8'h04, d); chk("R6 both pending", d, 32'h3);
        chk("R12 irq masked", 32'(irq), 32'd0);
        wr(8'h00, 32'h2);
        chk("R12 irq from channel 1", 32'(irq), 32'd1);
        wr(8'h04, 32'h0);
        rd(8'h04, d); chk("R11 write zero keeps", d, 32'h3);
        wr(8'h04, 32'h1);
        rd(8'h04, d); chk("R11 clear bit 0 only", d, 32'h2);
        chk("R12 irq still high", 32'(irq), 32'd1);
        wr(8'h04, 32'h2);
        chk("R12 irq dropped", 32'(irq), 32'd0);
        wr(8'h00, 32'h0);

        // Sweep: channel, prescaler, source, mode
        for (int ch = 0; ch < 2; ch++)
            for (int k = 0; k < 4; k++)
                for (int src = 0; src < 2; src++)
                    for (int os = 0; os < 2; os++)
                        run_case(ch, k, src, bit'(os), 1 + ((k + src) % 2));

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (180000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule